// File: doc/BRIEF.md
# SPI serial memory slave interface

This block is the serial front end of a small byte-wide memory. It runs on the chip's system clock and oversamples the SPI pins through a synchronizer, so the serial clock must be much slower than the system clock (at least eight system cycles per serial clock phase). A frame opens when chip select falls. The first byte is an instruction. For reads and writes, address bytes follow, then data bytes. The block shifts read data and status bytes out on the serial output, and presents read requests, write requests, an address and write data to the memory core behind it.

An active-low hold input pauses a frame without losing the bits already shifted. An active-low write-protect input and an internal write-enable latch together decide whether a write is passed to the core. A write goes to the core only when chip select rises at the end of a complete write frame, so nothing that happens after that point can cancel it. The core answers a read request with its data one system clock later.

Top module: `sms_spi_slave`

## Requirements
- R1: Input bits are taken on rising serial-clock edges, most significant bit first, from the first rising edge after chip select falls. This works with the clock idling low (mode 0) and with the clock idling high (mode 3).
- R2: Output bytes change on falling serial-clock edges, most significant bit first. The first output bit appears on the first falling edge after the last instruction or address bit.
- R3: While chip select is high, `spi_miso_oe` is low. During the output phase of a selected frame, `spi_miso_oe` is high.
- R4: While `spi_hold_n` is low, `spi_miso_oe` is low and serial clock edges are ignored. When hold is released, shifting continues from the same bit.
- R5: Instruction 0x06 sets the write-enable latch and instruction 0x04 clears it. Instruction 0x05 returns the status byte on every following output byte. In the status byte, bit 1 is the latch and bit 7 is 1 while write protect is low; all other bits are 0.
- R6: Instruction 0x02 is followed by one address byte and data bytes. When chip select rises, if at least one full data byte was received, the latch is set and write protect is high, the block raises `wr_req` for exactly one cycle with the address and the last complete data byte, and it clears the latch.
- R7: While write protect is low, no write request is issued and the latch keeps its value. Reads and status reads still work.
- R8: When chip select rises, any partial byte is discarded, and the next frame starts with a fresh instruction byte.
- R9: Instruction 0x03 is followed by one address byte. The block then streams bytes from consecutive addresses, each fetched with a one-cycle `rd_req` pulse.
- R10: A write frame whose data byte is incomplete issues no write. `rd_req` and `wr_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause, active low |
| spi_wp_n | input | 1 | Write protect, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| rd_req | output | 1 | One-cycle read request to the core |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_req` |
| wr_req | output | 1 | One-cycle write request to the core |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data |

## Verification
Writes and status reads run in mode 0, and a three-byte read runs in mode 3, so an edge-polarity mistake shows up in one of the two modes. The bench compares status bytes across set, clear, commit and protected sequences. This separates a latch that was never set from one that a write cleared and from one that write protect wrongly cleared. Truncated data bytes and garbage partial frames show whether framing restarts when chip select rises. A hold placed mid-byte, with clock pulses sent during the hold, shows whether bits are lost or counted twice.

// File: rtl/sms_pkg.sv
package sms_pkg;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/sms_sync.sv
module sms_sync #(
    parameter int W = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sms_wel.sv
module sms_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic wel
);
    logic wel_d, wel_q;

    always_comb begin
        wel_d = wel_q;
        if (set)      wel_d = 1'b1;
        else if (clr) wel_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wel_q <= 1'b0;
        else        wel_q <= wel_d;
    end

    assign wel = wel_q;
endmodule

// File: rtl/sms_spi_slave.sv
module sms_spi_slave #(
    parameter int ADDR_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    input  logic              spi_wp_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    import sms_pkg::*;

    localparam int AB   = ADDR_W / 8;
    localparam int AB_W = $clog2(AB + 1);

    typedef struct packed {
        phase_e            ph;
        logic [2:0]        bit_cnt;
        logic [7:0]        rx;
        logic [7:0]        tx;
        logic              so;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [AB_W-1:0]   ab_cnt;
        logic [7:0]        wbuf;
        logic              wvalid;
        logic              rd_req;
        logic              load_tx;
        logic              wr_req;
        logic              sclk_p;
        logic              cs_p;
    } st_t;

    st_t st_d, st_q;

    logic [4:0] pins_s;
    logic sclk_s, cs_s, mosi_s, hold_s, wp_s;
    logic wel, wel_set, wel_clr;
    logic rise, fall;
    logic [7:0] rx_byte, status;

    sms_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01011)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk, spi_cs_n, spi_mosi, spi_hold_n, spi_wp_n}),
        .q(pins_s)
    );
    assign {sclk_s, cs_s, mosi_s, hold_s, wp_s} = pins_s;

    sms_wel u_wel (
        .clk(clk), .rst_n(rst_n), .set(wel_set), .clr(wel_clr), .wel(wel)
    );

    assign rise    = sclk_s & ~st_q.sclk_p;
    assign fall    = ~sclk_s & st_q.sclk_p;
    assign rx_byte = {st_q.rx[6:0], mosi_s};
    assign status  = {~wp_s, 5'b0, wel, 1'b0};

    always_comb begin
        st_d        = st_q;
        st_d.rd_req = 1'b0;
        st_d.wr_req = 1'b0;
        st_d.sclk_p = sclk_s;
        st_d.cs_p   = cs_s;
        wel_set     = 1'b0;
        wel_clr     = 1'b0;

        if (st_q.load_tx) begin
            st_d.tx      = rd_data;
            st_d.load_tx = 1'b0;
        end
        if (st_q.rd_req) begin
            st_d.addr    = st_q.addr + 1'b1;
            st_d.load_tx = 1'b1;
        end

        if (cs_s) begin
            st_d.ph      = PH_CMD;
            st_d.bit_cnt = '0;
            st_d.wvalid  = 1'b0;
            st_d.so      = 1'b0;
            if (!st_q.cs_p && st_q.ph == PH_WDATA && st_q.wvalid && wel && wp_s) begin
                st_d.wr_req = 1'b1;
                wel_clr     = 1'b1;
            end
        end else if (hold_s) begin
            if (rise) begin
                st_d.rx      = rx_byte;
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    case (st_q.ph)
                        PH_CMD: begin
                            st_d.ab_cnt = '0;
                            case (rx_byte)
                                OP_WREN: begin wel_set = 1'b1; st_d.ph = PH_SKIP; end
                                OP_WRDI: begin wel_clr = 1'b1; st_d.ph = PH_SKIP; end
                                OP_RDSR: begin st_d.tx = status; st_d.ph = PH_STAT; end
                                OP_READ: begin st_d.is_wr = 1'b0; st_d.ph = PH_ADDR; end
                                OP_WRITE: begin st_d.is_wr = 1'b1; st_d.ph = PH_ADDR; end
                                default: st_d.ph = PH_SKIP;
                            endcase
                        end
                        PH_ADDR: begin
                            st_d.addr = (st_q.addr << 8) | ADDR_W'(rx_byte);
                            if (st_q.ab_cnt == AB_W'(AB - 1)) begin
                                if (st_q.is_wr) begin
                                    st_d.ph = PH_WDATA;
                                end else begin
                                    st_d.ph     = PH_RDATA;
                                    st_d.rd_req = 1'b1;
                                end
                            end else begin
                                st_d.ab_cnt = st_q.ab_cnt + 1'b1;
                            end
                        end
                        PH_WDATA: begin
                            st_d.wbuf   = rx_byte;
                            st_d.wvalid = 1'b1;
                        end
                        PH_RDATA: st_d.rd_req = 1'b1;
                        PH_STAT:  st_d.tx = status;
                        default: ;
                    endcase
                end
            end else if (fall && (st_q.ph == PH_RDATA || st_q.ph == PH_STAT)) begin
                st_d.so = st_q.tx[7];
                st_d.tx = {st_q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ph     <= PH_CMD;
            st_q.cs_p   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso    = st_q.so;
    assign spi_miso_oe = ~cs_s & hold_s & (st_q.ph == PH_RDATA || st_q.ph == PH_STAT);
    assign rd_req      = st_q.rd_req;
    assign rd_addr     = st_q.addr;
    assign wr_req      = st_q.wr_req;
    assign wr_addr     = st_q.addr;
    assign wr_data     = st_q.wbuf;
endmodule

// File: rtl/sms_spi_chk.sv
module sms_spi_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_hold_n,
    input logic spi_miso_oe,
    input logic rd_req,
    input logic wr_req,
    input logic wp_s,
    input logic wel
);
    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R3
    AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(spi_hold_n, 1) && !$past(spi_hold_n, 2) && !$past(spi_hold_n, 3)) |-> !spi_miso_oe); // R4
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R6
    AST_WR_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !wel); // R6
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ($past(wel) && $past(wp_s))); // R7
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R9
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R10
endmodule

bind sms_spi_slave sms_spi_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .spi_cs_n(spi_cs_n),
    .spi_hold_n(spi_hold_n),
    .spi_miso_oe(spi_miso_oe),
    .rd_req(rd_req),
    .wr_req(wr_req),
    .wp_s(wp_s),
    .wel(wel)
);

// File: tb/sms_spi_slave_bench.sv
module sms_spi_slave_bench;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_hold_n = 1'b1, spi_wp_n = 1'b1;
    logic spi_miso, spi_miso_oe, rd_req, wr_req;
    logic [7:0] rd_addr, wr_addr, wr_data;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] mem [256];
    int checks = 0, errors = 0, wr_cnt = 0;
    logic [7:0] last_wa = 8'h00, last_wd = 8'h00;
    bit m3 = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sms_spi_slave u_sms_spi_slave (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_hold_n(spi_hold_n), .spi_wp_n(spi_wp_n),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] pre(input int i);
        return 8'(i * 13 + 8'h5A);
    endfunction

    always @(posedge clk) begin
        if (rd_req) rd_data <= mem[rd_addr];
        if (wr_req) begin
            mem[wr_addr] <= wr_data;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= wr_addr;
            last_wd <= wr_data;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic sel();
        spi_sclk = m3;
        w(4);
        spi_cs_n = 1'b0;
        w(H);
    endtask

    task automatic desel();
        if (!m3) begin spi_sclk = 1'b0; w(H); end
        spi_cs_n = 1'b1;
        w(8);
    endtask

    task automatic xbit(input bit b, output bit o);
        spi_sclk = 1'b0;
        spi_mosi = b;
        w(H);
        o = spi_miso;
        spi_sclk = 1'b1;
        w(H);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) begin
            bit r;
            xbit(b[i], r);
            o[i] = r;
        end
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xbyte(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] d;
        sel(); xbyte(8'h05, d); xbyte(8'h00, st); desel();
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel(); xbyte(8'h02, d); xbyte(a, d); xbyte(v, d); desel();
    endtask

    task automatic t_reset();
        chk("R3", "oe after reset", spi_miso_oe, 0);
        chk("R6", "wr_req after reset", wr_req, 0);
        chk("R9", "rd_req after reset", rd_req, 0);
    endtask

    task automatic t_status_latch();
        logic [7:0] st;
        rdsr(st);
        chk("R5", "status after reset", st, 8'h00);
        op1(8'h06);
        m3 = 1'b1;
        rdsr(st);
        chk("R5", "status after 0x06 (mode 3, R2)", st, 8'h02);
        m3 = 1'b0; spi_sclk = 1'b0; w(4);
        op1(8'h04);
        rdsr(st);
        chk("R5", "status after 0x04", st, 8'h00);
    endtask

    task automatic t_write_ok();
        logic [7:0] st;
        int n0 = wr_cnt;
        op1(8'h06);
        wr1(8'h10, 8'hA5);
        chk("R6", "write count", wr_cnt - n0, 1);
        chk("R1", "write address", last_wa, 8'h10);
        chk("R1", "write data", last_wd, 8'hA5);
        rdsr(st);
        chk("R6", "latch cleared by write", st, 8'h00);
        n0 = wr_cnt;
        wr1(8'h11, 8'h99);
        chk("R6", "write without latch", wr_cnt - n0, 0);
    endtask

    task automatic t_protect();
        logic [7:0] st, d, v;
        int n0;
        spi_wp_n = 1'b0; w(4);
        op1(8'h06);
        n0 = wr_cnt;
        wr1(8'h40, 8'h77);
        chk("R7", "protected write count", wr_cnt - n0, 0);
        rdsr(st);
        chk("R7", "status while protected", st, 8'h82);
        sel(); xbyte(8'h03, d); xbyte(8'h40, d); xbyte(8'h00, v); desel();
        chk("R7", "read while protected", v, pre(8'h40));
        spi_wp_n = 1'b1; w(4);
        op1(8'h04);
    endtask

    task automatic t_read_mode3();
        logic [7:0] d, v0, v1, v2;
        m3 = 1'b1;
        sel();
        xbyte(8'h03, d); xbyte(8'h10, d);
        chk("R3", "oe in output phase", spi_miso_oe, 1);
        xbyte(8'h00, v0); xbyte(8'h00, v1); xbyte(8'h00, v2);
        desel();
        chk("R2", "mode 3 read byte 0", v0, 8'hA5);
        chk("R9", "mode 3 read byte 1", v1, pre(8'h11));
        chk("R9", "mode 3 read byte 2", v2, pre(8'h12));
        m3 = 1'b0; spi_sclk = 1'b0; w(4);
        chk("R3", "oe after deselect", spi_miso_oe, 0);
    endtask

    task automatic t_partial();
        logic [7:0] d, st;
        bit r;
        int n0;
        op1(8'h06);
        n0 = wr_cnt;
        sel(); xbyte(8'h02, d); xbyte(8'h30, d);
        for (int i = 0; i < 5; i++) xbit(1'b1, r);
        desel();
        chk("R10", "truncated data byte write count", wr_cnt - n0, 0);
        sel();
        for (int i = 0; i < 3; i++) xbit(1'b1, r);
        desel();
        rdsr(st);
        chk("R8", "status after partial frame", st, 8'h02);
        n0 = wr_cnt;
        sel(); xbyte(8'h02, d); xbyte(8'h50, d); xbyte(8'h11, d); xbyte(8'h22, d); desel();
        chk("R6", "two-byte write count", wr_cnt - n0, 1);
        chk("R6", "two-byte write last data", last_wd, 8'h22);
        chk("R6", "two-byte write address", last_wa, 8'h50);
    endtask

    task automatic t_hold();
        logic [7:0] d, v;
        bit r;
        sel(); xbyte(8'h03, d); xbyte(8'h20, d);
        for (int i = 7; i >= 4; i--) begin xbit(1'b0, r); v[i] = r; end
        spi_sclk = 1'b0; w(H);
        spi_hold_n = 1'b0; w(6);
        chk("R4", "oe during hold", spi_miso_oe, 0);
        for (int i = 0; i < 2; i++) begin
            spi_sclk = 1'b1; w(H);
            spi_sclk = 1'b0; w(H);
        end
        spi_hold_n = 1'b1; w(6);
        chk("R4", "oe after hold release", spi_miso_oe, 1);
        for (int i = 3; i >= 0; i--) begin xbit(1'b0, r); v[i] = r; end
        desel();
        chk("R4", "byte read across hold", v, pre(8'h20));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pre(i);
        w(10);
        rst_n = 1'b1;
        w(10);
        t_reset();
        t_status_latch();
        t_write_ok();
        t_protect();
        t_read_mode3();
        t_partial();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule